// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes fixed 32-byte interrupt vectors from an upstream producer and stores them one after another in a circular buffer in memory, through a plain write port. It keeps the producer position (write pointer) and holds the consumer position (read pointer). Software moves the read pointer with a direct register write or with a doorbell write. An interrupt output tells software that unread vectors are waiting.

Software places the ring with a 32-bit base value, which gives bits [39:8] of the byte address. It sizes the ring as a power of two counted in 32-bit words. It then picks what happens when a vector arrives and the ring is full. In overwrite mode the vector is written anyway and a sticky overflow flag is raised in bit 31 of the write-pointer word. In drain mode the producer is held off until the consumer frees a slot. The block can also copy every new write-pointer word to a writeback address, so software can poll memory instead of a register.

Top module: `ivring_writer`

## Requirements
- R1: After reset the write-pointer word, the read pointer, the interrupt, both write strobes and vec_ready are all 0.
- R2: An accepted vector (vec_valid and vec_ready high at a clock edge) appears on the memory port at the next edge. The address is base×256 plus the old write pointer, and the data is the vector unchanged. The write pointer then advances by 32, modulo the ring size. The ring size in bytes is 4×2^S, where S is control bits [11:7], clamped to between 32 bytes and 2^PTR_W bytes. Pointers written by software are masked to the ring size and aligned to 32.
- R3: The write pointer wraps to 0 after the last 32-byte slot of the ring.
- R4: The ring is full when (wptr+32) mod size equals rptr. With overwrite enabled (control bit 2) and drain off, a vector arriving while full is still written and the write pointer still advances. Bit 31 of the write-pointer word is then set and stays set across later writes.
- R5: The overflow flag clears only when a control write takes bit 3 from 0 to 1. Writing bit 3 as 0, or writing it as 1 while it already holds 1, leaves the flag unchanged.
- R6: With drain (control bit 4) set and the ring full, vec_ready is low and no write occurs. Once the read pointer frees a slot, the held vector is accepted.
- R7: With the ring enable (control bit 0) low, vec_ready is low and vectors are not written. Software writes to the write pointer and the read pointer still load.
- R8: With writeback (control bit 5) set, each accepted vector also causes a write of the new write-pointer word to the programmed writeback address, in the same cycle as the memory write. With bit 5 clear, no writeback write occurs.
- R9: With doorbell mode (control bit 6) set, only doorbell writes move the read pointer. With it clear, only register writes move it.
- R10: irq is high exactly while the ring is enabled, interrupt enable (control bit 1) is set, and the write pointer differs from the read pointer.
- R11: With both overwrite and drain off, a vector arriving while full is written and the pointer advances, but the overflow flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_valid | input | 1 | Producer offers a vector |
| vec_data | input | DATA_W | Vector payload (32 bytes by default) |
| vec_ready | output | 1 | Block can take a vector this cycle |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 12 | Control value: [0] enable, [1] irq enable, [2] overwrite, [3] overflow clear, [4] drain, [5] writeback, [6] doorbell mode, [11:7] size log2 words |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | BASE_W | Byte address bits [39:8] of ring start |
| wba_wr | input | 1 | Writeback address write strobe |
| wba_wdata | input | BASE_W+8 | Writeback byte address |
| wptr_wr | input | 1 | Software write of the write pointer |
| wptr_wdata | input | PTR_W | New write pointer (bytes) |
| rptr_wr | input | 1 | Register write of the read pointer |
| rptr_wdata | input | PTR_W | New read pointer via register |
| db_wr | input | 1 | Doorbell write of the read pointer |
| db_wdata | input | PTR_W | New read pointer via doorbell |
| wptr_word | output | 32 | [31] overflow flag, [PTR_W-1:0] write pointer |
| rptr_out | output | PTR_W | Current read pointer |
| irq | output | 1 | Unread vectors pending |
| mem_wr_en | output | 1 | Ring memory write strobe |
| mem_wr_addr | output | BASE_W+8 | Ring memory byte address |
| mem_wr_data | output | DATA_W | Ring memory write data |
| wb_wr_en | output | 1 | Writeback write strobe |
| wb_wr_addr | output | BASE_W+8 | Writeback byte address |
| wb_wr_data | output | 32 | Writeback data (write-pointer word) |

## Verification
A wrong pointer or a wrong ring mask shows up on the memory address at the next accepted vector. It also shows on wptr_word and on the writeback data in that same cycle, so a single bad increment or a missed wrap is visible one edge after it happens. A lost or stuck overflow flag shows in bit 31 one cycle after the full-ring write or the clear write. A wrong full decision shows at once as vec_ready in drain mode, or as a missing flag in overwrite mode. Read-pointer path errors show at once on rptr_out and irq.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int unsigned VEC_BYTES = 32;
    localparam int unsigned VEC_SHIFT = 5;
    localparam int unsigned CTL_W     = 12;

    // control word, bit 0 upward: enable, irq enable, overwrite, clear,
    // drain, writeback, doorbell mode, then log2 of size in words
    typedef struct packed {
        logic [4:0] size_lg;
        logic       db_on;
        logic       wb_on;
        logic       drain_on;
        logic       ovf_clr;
        logic       ovf_on;
        logic       irq_on;
        logic       ring_on;
    } ivr_ctl_t;
endpackage

// File: rtl/ivr_ctl_regs.sv
module ivr_ctl_regs
    import ivr_pkg::*;
#(
    parameter int BASE_W = 32,
    parameter int ADDR_W = BASE_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              base_wr,
    input  logic [BASE_W-1:0] base_wdata,
    input  logic              wba_wr,
    input  logic [ADDR_W-1:0] wba_wdata,
    output logic              ring_on,
    output logic              irq_on,
    output logic              ovf_on,
    output logic              drain_on,
    output logic              wb_on,
    output logic              db_on,
    output logic [4:0]        size_lg,
    output logic              clr_pulse,
    output logic [BASE_W-1:0] base_q,
    output logic [ADDR_W-1:0] wba_q
);
    typedef struct packed {
        ivr_ctl_t          ctl;
        logic [BASE_W-1:0] base;
        logic [ADDR_W-1:0] wba;
    } regs_t;

    regs_t    r_d, r_q;
    ivr_ctl_t wr_view;

    always_comb begin
        wr_view = ivr_ctl_t'(ctl_wdata);
        r_d     = r_q;
        if (ctl_wr)  r_d.ctl  = wr_view;
        if (base_wr) r_d.base = base_wdata;
        if (wba_wr)  r_d.wba  = wba_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // clear acts only on a 0 -> 1 change of the stored clear bit
    assign clr_pulse = ctl_wr && wr_view.ovf_clr && !r_q.ctl.ovf_clr;
    assign ring_on   = r_q.ctl.ring_on;
    assign irq_on    = r_q.ctl.irq_on;
    assign ovf_on    = r_q.ctl.ovf_on;
    assign drain_on  = r_q.ctl.drain_on;
    assign wb_on     = r_q.ctl.wb_on;
    assign db_on     = r_q.ctl.db_on;
    assign size_lg   = r_q.ctl.size_lg;
    assign base_q    = r_q.base;
    assign wba_q     = r_q.wba;
endmodule

// File: rtl/ivr_ptr_unit.sv
module ivr_ptr_unit
    import ivr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_on,
    input  logic             ovf_on,
    input  logic             drain_on,
    input  logic             db_on,
    input  logic [4:0]       size_lg,
    input  logic             clr_pulse,
    input  logic             vec_valid,
    input  logic             wptr_wr,
    input  logic [PTR_W-1:0] wptr_wdata,
    input  logic             rptr_wr,
    input  logic [PTR_W-1:0] rptr_wdata,
    input  logic             db_wr,
    input  logic [PTR_W-1:0] db_wdata,
    output logic             vec_ready,
    output logic             accept,
    output logic [PTR_W-1:0] wptr_q_o,
    output logic [PTR_W-1:0] rptr_q_o,
    output logic             ovf_q_o,
    output logic [PTR_W-1:0] wptr_d_o,
    output logic             ovf_d_o
);
    localparam logic [5:0]       MIN_LG = 6'(VEC_SHIFT);
    localparam logic [5:0]       MAX_LG = 6'(PTR_W);
    localparam logic [PTR_W-1:0] STEP   = PTR_W'(VEC_BYTES);
    localparam logic [PTR_W-1:0] ALIGN  = ~PTR_W'(VEC_BYTES - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic             ovf;
    } ptr_t;

    ptr_t             s_d, s_q;
    logic [5:0]       lg;
    logic [PTR_W:0]   one_sh;
    logic [PTR_W-1:0] mask, nxt;
    logic             full, rdy, acc, rload;
    logic [PTR_W-1:0] rsrc;

    always_comb begin
        lg = {1'b0, size_lg} + 6'd2;
        if (lg < MIN_LG) lg = MIN_LG;
        if (lg > MAX_LG) lg = MAX_LG;
        one_sh = (PTR_W+1)'(1) << lg;
        mask   = one_sh[PTR_W-1:0] - PTR_W'(1);

        nxt  = (s_q.wptr + STEP) & mask;
        full = (nxt == s_q.rptr);
        rdy  = ring_on && !(drain_on && full);
        acc  = vec_valid && rdy;

        s_d = s_q;
        if (clr_pulse) s_d.ovf = 1'b0;
        if (acc) begin
            s_d.wptr = nxt;
            if (full && ovf_on) s_d.ovf = 1'b1;
        end else if (wptr_wr) begin
            s_d.wptr = wptr_wdata & mask & ALIGN;
        end

        rload = db_on ? db_wr : rptr_wr;
        rsrc  = db_on ? db_wdata : rptr_wdata;
        if (rload) s_d.rptr = rsrc & mask & ALIGN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign vec_ready = rdy;
    assign accept    = acc;
    assign wptr_q_o  = s_q.wptr;
    assign rptr_q_o  = s_q.rptr;
    assign ovf_q_o   = s_q.ovf;
    assign wptr_d_o  = s_d.wptr;
    assign ovf_d_o   = s_d.ovf;
endmodule

// File: rtl/ivr_out_stage.sv
module ivr_out_stage #(
    parameter int DATA_W = 256,
    parameter int BASE_W = 32,
    parameter int PTR_W  = 16,
    parameter int ADDR_W = BASE_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              wb_on,
    input  logic [BASE_W-1:0] base_q,
    input  logic [PTR_W-1:0]  wptr_q,
    input  logic [DATA_W-1:0] vec_data,
    input  logic [ADDR_W-1:0] wba_q,
    input  logic [31:0]       wword_d,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              wb_wr_en,
    output logic [ADDR_W-1:0] wb_wr_addr,
    output logic [31:0]       wb_wr_data
);
    typedef struct packed {
        logic              men;
        logic [ADDR_W-1:0] maddr;
        logic [DATA_W-1:0] mdata;
        logic              wen;
        logic [ADDR_W-1:0] waddr;
        logic [31:0]       wdata;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.men = accept;
        o_d.wen = accept && wb_on;
        if (accept) begin
            o_d.maddr = {base_q, 8'h00} + ADDR_W'(wptr_q);
            o_d.mdata = vec_data;
        end
        if (accept && wb_on) begin
            o_d.waddr = wba_q;
            o_d.wdata = wword_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign mem_wr_en   = o_q.men;
    assign mem_wr_addr = o_q.maddr;
    assign mem_wr_data = o_q.mdata;
    assign wb_wr_en    = o_q.wen;
    assign wb_wr_addr  = o_q.waddr;
    assign wb_wr_data  = o_q.wdata;
endmodule

// File: rtl/ivring_writer.sv
module ivring_writer
    import ivr_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int BASE_W = 32,
    parameter int PTR_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vec_valid,
    input  logic [DATA_W-1:0]   vec_data,
    output logic                vec_ready,
    input  logic                ctl_wr,
    input  logic [CTL_W-1:0]    ctl_wdata,
    input  logic                base_wr,
    input  logic [BASE_W-1:0]   base_wdata,
    input  logic                wba_wr,
    input  logic [BASE_W+7:0]   wba_wdata,
    input  logic                wptr_wr,
    input  logic [PTR_W-1:0]    wptr_wdata,
    input  logic                rptr_wr,
    input  logic [PTR_W-1:0]    rptr_wdata,
    input  logic                db_wr,
    input  logic [PTR_W-1:0]    db_wdata,
    output logic [31:0]         wptr_word,
    output logic [PTR_W-1:0]    rptr_out,
    output logic                irq,
    output logic                mem_wr_en,
    output logic [BASE_W+7:0]   mem_wr_addr,
    output logic [DATA_W-1:0]   mem_wr_data,
    output logic                wb_wr_en,
    output logic [BASE_W+7:0]   wb_wr_addr,
    output logic [31:0]         wb_wr_data
);
    localparam int ADDR_W = BASE_W + 8;
    localparam int PAD_W  = 31 - PTR_W;

    logic              ring_on, irq_on, ovf_on, drain_on, wb_on, db_on, clr_pulse;
    logic [4:0]        size_lg;
    logic [BASE_W-1:0] base_q;
    logic [ADDR_W-1:0] wba_q;
    logic              accept, ovf_q, ovf_d;
    logic [PTR_W-1:0]  wptr_q, rptr_q, wptr_d;
    logic [31:0]       wword_d;

    ivr_ctl_regs #(.BASE_W(BASE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .base_wr(base_wr), .base_wdata(base_wdata),
        .wba_wr(wba_wr), .wba_wdata(wba_wdata),
        .ring_on(ring_on), .irq_on(irq_on), .ovf_on(ovf_on),
        .drain_on(drain_on), .wb_on(wb_on), .db_on(db_on),
        .size_lg(size_lg), .clr_pulse(clr_pulse),
        .base_q(base_q), .wba_q(wba_q)
    );

    ivr_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .ring_on(ring_on), .ovf_on(ovf_on), .drain_on(drain_on),
        .db_on(db_on), .size_lg(size_lg), .clr_pulse(clr_pulse),
        .vec_valid(vec_valid),
        .wptr_wr(wptr_wr), .wptr_wdata(wptr_wdata),
        .rptr_wr(rptr_wr), .rptr_wdata(rptr_wdata),
        .db_wr(db_wr), .db_wdata(db_wdata),
        .vec_ready(vec_ready), .accept(accept),
        .wptr_q_o(wptr_q), .rptr_q_o(rptr_q), .ovf_q_o(ovf_q),
        .wptr_d_o(wptr_d), .ovf_d_o(ovf_d)
    );

    assign wword_d = {ovf_d, {PAD_W{1'b0}}, wptr_d};

    ivr_out_stage #(.DATA_W(DATA_W), .BASE_W(BASE_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .wb_on(wb_on),
        .base_q(base_q), .wptr_q(wptr_q), .vec_data(vec_data),
        .wba_q(wba_q), .wword_d(wword_d),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .wb_wr_en(wb_wr_en), .wb_wr_addr(wb_wr_addr), .wb_wr_data(wb_wr_data)
    );

    assign wptr_word = {ovf_q, {PAD_W{1'b0}}, wptr_q};
    assign rptr_out  = rptr_q;
    assign irq       = ring_on && irq_on && (wptr_q != rptr_q);
endmodule

// File: rtl/ivring_writer_chk.sv
module ivring_writer_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vec_valid,
    input logic             vec_ready,
    input logic             ctl_wr,
    input logic             clr_bit,
    input logic             ovf_flag,
    input logic [PTR_W-1:0] wptr,
    input logic [PTR_W-1:0] rptr_out,
    input logic             irq,
    input logic             mem_wr_en,
    input logic             wb_wr_en,
    input logic [31:0]      wb_wr_data
);
    // R2
    mem_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(vec_valid && vec_ready));

    // R2
    ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr[4:0] == 5'd0) && (rptr_out[4:0] == 5'd0));

    // R4
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> mem_wr_en);

    // R5
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(ctl_wr && clr_bit));

    // R8
    wb_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_wr_en |-> (mem_wr_en && wb_wr_data[31] == ovf_flag
                      && wb_wr_data[PTR_W-1:0] == wptr));

    // R10
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (wptr != rptr_out));
endmodule

bind ivring_writer ivring_writer_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .vec_valid(vec_valid), .vec_ready(vec_ready),
    .ctl_wr(ctl_wr), .clr_bit(ctl_wdata[3]),
    .ovf_flag(wptr_word[31]), .wptr(wptr_word[PTR_W-1:0]),
    .rptr_out(rptr_out), .irq(irq),
    .mem_wr_en(mem_wr_en), .wb_wr_en(wb_wr_en), .wb_wr_data(wb_wr_data)
);

// File: tb/ivring_writer_bench.sv
`timescale 1ns/1ps
module ivring_writer_bench;
    localparam int DW = 256;
    localparam int BW = 32;
    localparam int PW = 16;
    localparam int AW = BW + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vec_valid = 0, ctl_wr = 0, base_wr = 0, wba_wr = 0;
    logic wptr_wr = 0, rptr_wr = 0, db_wr = 0;
    logic [DW-1:0] vec_data = '0;
    logic [11:0]   ctl_wdata = '0;
    logic [BW-1:0] base_wdata = '0;
    logic [AW-1:0] wba_wdata = '0;
    logic [PW-1:0] wptr_wdata = '0, rptr_wdata = '0, db_wdata = '0;
    logic          vec_ready, irq, mem_wr_en, wb_wr_en;
    logic [31:0]   wptr_word, wb_wr_data;
    logic [PW-1:0] rptr_out;
    logic [AW-1:0] mem_wr_addr, wb_wr_addr;
    logic [DW-1:0] mem_wr_data;

    always #2 clk = ~clk;

    ivring_writer #(.DATA_W(DW), .BASE_W(BW), .PTR_W(PW)) u_ivring_writer (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_data(vec_data),
        .vec_ready(vec_ready), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .base_wr(base_wr), .base_wdata(base_wdata), .wba_wr(wba_wr),
        .wba_wdata(wba_wdata), .wptr_wr(wptr_wr), .wptr_wdata(wptr_wdata),
        .rptr_wr(rptr_wr), .rptr_wdata(rptr_wdata), .db_wr(db_wr),
        .db_wdata(db_wdata), .wptr_word(wptr_word), .rptr_out(rptr_out),
        .irq(irq), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .wb_wr_en(wb_wr_en), .wb_wr_addr(wb_wr_addr),
        .wb_wr_data(wb_wr_data)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_w, m_r, m_lg, m_mask, m_nxt;
    bit          m_ovf, m_full, m_acc;
    logic [11:0] m_ctl;
    logic [BW-1:0] m_base;
    logic [AW-1:0] m_wba, m_addr, m_wbaddr;
    logic [DW-1:0] m_data;
    bit          m_men, m_wen;
    logic [31:0] m_wbdata;

    function automatic int mask_of(logic [11:0] c);
        int lg = int'(c[11:7]) + 2;
        if (lg < 5) lg = 5;
        if (lg > PW) lg = PW;
        return (1 << lg) - 1;
    endfunction

    function automatic bit model_full();
        return (((m_w + 32) & mask_of(m_ctl)) == m_r);
    endfunction

    function automatic bit model_ready();
        return m_ctl[0] && !(m_ctl[4] && model_full());
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_w = 0; m_r = 0; m_ovf = 0; m_ctl = '0; m_base = '0; m_wba = '0;
            m_men = 0; m_wen = 0; m_addr = '0; m_data = '0; m_wbaddr = '0; m_wbdata = '0;
        end else begin
            m_mask = mask_of(m_ctl);
            m_full = model_full();
            m_acc  = vec_valid && model_ready();
            m_nxt  = (m_w + 32) & m_mask;
            m_men  = m_acc;
            if (m_acc) begin
                m_addr = {m_base, 8'h00} + AW'(m_w);
                m_data = vec_data;
            end
            if (ctl_wr && ctl_wdata[3] && !m_ctl[3]) m_ovf = 0;
            if (m_acc) begin
                if (m_full && m_ctl[2]) m_ovf = 1;
                m_w = m_nxt;
            end else if (wptr_wr) begin
                m_w = int'(wptr_wdata) & m_mask & ~31;
            end
            if (m_ctl[6] ? db_wr : rptr_wr)
                m_r = int'(m_ctl[6] ? db_wdata : rptr_wdata) & m_mask & ~31;
            m_wen = m_acc && m_ctl[5];
            if (m_wen) begin
                m_wbaddr = m_wba;
                m_wbdata = {m_ovf, 15'd0, 16'(m_w)};
            end
            if (ctl_wr)  m_ctl  = ctl_wdata;
            if (base_wr) m_base = base_wdata;
            if (wba_wr)  m_wba  = wba_wdata;
        end
    end

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "model wptr_word", DW'(wptr_word), DW'({m_ovf, 15'd0, 16'(m_w)}));
            check(cur_req, "model rptr", DW'(rptr_out), DW'(m_r));
            check(cur_req, "model irq", DW'(irq), DW'(m_ctl[0] && m_ctl[1] && (m_w != m_r)));
            check(cur_req, "model vec_ready", DW'(vec_ready), DW'(model_ready()));
            check(cur_req, "model mem_wr_en", DW'(mem_wr_en), DW'(m_men));
            check(cur_req, "model wb_wr_en", DW'(wb_wr_en), DW'(m_wen));
            if (m_men) begin
                check(cur_req, "model mem addr", DW'(mem_wr_addr), DW'(m_addr));
                check(cur_req, "model mem data", mem_wr_data, m_data);
            end
            if (m_wen) begin
                check(cur_req, "model wb addr", DW'(wb_wr_addr), DW'(m_wbaddr));
                check(cur_req, "model wb data", DW'(wb_wr_data), DW'(m_wbdata));
            end
        end
    end

    function automatic logic [11:0] mk(bit on, bit ie, bit ov, bit clr, bit dr, bit wb, bit db, int sz);
        return {5'(sz), db, wb, dr, clr, ov, ie, on};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_ctl(logic [11:0] v);
        ctl_wr = 1; ctl_wdata = v; tick(); ctl_wr = 0;
    endtask

    task automatic push(logic [DW-1:0] d);
        vec_valid = 1; vec_data = d; tick(); vec_valid = 0;
    endtask

    task automatic set_rptr(int v);
        rptr_wr = 1; rptr_wdata = PW'(v); tick(); rptr_wr = 0;
    endtask

    task automatic ring_db(int v);
        db_wr = 1; db_wdata = PW'(v); tick(); db_wr = 0;
    endtask

    localparam logic [AW-1:0] BASE_ADDR = 40'h0001234500;

    bit done = 0;
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1", "wptr_word", DW'(wptr_word), '0);
        check("R1", "rptr", DW'(rptr_out), '0);
        check("R1", "irq", DW'(irq), '0);
        check("R1", "mem_wr_en", DW'(mem_wr_en), '0);
        check("R1", "vec_ready", DW'(vec_ready), '0);

        cur_req = "R2";
        base_wr = 1; base_wdata = 32'h00012345; tick(); base_wr = 0;
        wba_wr = 1; wba_wdata = 40'h00_0ABC_0040; tick(); wba_wr = 0;
        wr_ctl(mk(1, 1, 0, 0, 0, 0, 0, 5));
        push({8{32'hA1A1_0001}});
        check("R2", "mem_wr_en", DW'(mem_wr_en), DW'(1));
        check("R2", "mem addr", DW'(mem_wr_addr), DW'(BASE_ADDR));
        check("R2", "mem data", mem_wr_data, {8{32'hA1A1_0001}});
        check("R2", "wptr", DW'(wptr_word), DW'(32));
        check("R8", "no wb when off", DW'(wb_wr_en), '0);
        check("R10", "irq pending", DW'(irq), DW'(1));
        push({8{32'hB2B2_0002}});
        check("R2", "mem addr second", DW'(mem_wr_addr), DW'(BASE_ADDR + 40'd32));
        check("R2", "wptr second", DW'(wptr_word), DW'(64));

        cur_req = "R10";
        wr_ctl(mk(1, 0, 0, 0, 0, 0, 0, 5));
        check("R10", "irq masked", DW'(irq), '0);

        cur_req = "R8";
        wr_ctl(mk(1, 1, 0, 0, 0, 1, 0, 5));
        set_rptr(64);
        push({8{32'hC3C3_0003}});
        check("R8", "wb en", DW'(wb_wr_en), DW'(1));
        check("R8", "wb addr", DW'(wb_wr_addr), DW'(40'h00_0ABC_0040));
        check("R8", "wb data", DW'(wb_wr_data), DW'(96));
        cur_req = "R3";
        push({8{32'hD4D4_0004}});
        check("R3", "wrap to 0", DW'(wptr_word), '0);
        check("R3", "wrap write addr", DW'(mem_wr_addr), DW'(BASE_ADDR + 40'd96));

        cur_req = "R4";
        wr_ctl(mk(1, 1, 1, 0, 0, 1, 0, 5));
        push({8{32'hE5E5_0005}});       // w=32, now full (r=64)
        check("R4", "flag not yet", DW'(wptr_word[31]), '0);
        push({8{32'hF6F6_0006}});
        check("R4", "full write done", DW'(mem_wr_en), DW'(1));
        check("R4", "flag set", DW'(wptr_word), DW'(32'h8000_0040));
        check("R4", "wb carries flag", DW'(wb_wr_data), DW'(32'h8000_0040));
        check("R10", "irq off when w==r", DW'(irq), '0);
        push({8{32'h1717_0007}});
        check("R4", "flag sticky", DW'(wptr_word), DW'(32'h8000_0060));

        cur_req = "R5";
        wr_ctl(mk(1, 1, 1, 0, 0, 1, 0, 5));
        check("R5", "clear bit 0 keeps flag", DW'(wptr_word[31]), DW'(1));
        wr_ctl(mk(1, 1, 1, 1, 0, 1, 0, 5));
        check("R5", "rising clear", DW'(wptr_word[31]), '0);
        push({8{32'h2828_0008}});      // w=0
        push({8{32'h3939_0009}});      // w=32 full
        push({8{32'h4A4A_000A}});      // overflow, w=64
        check("R5", "flag again", DW'(wptr_word[31]), DW'(1));
        wr_ctl(mk(1, 1, 1, 1, 0, 1, 0, 5));
        check("R5", "held clear no effect", DW'(wptr_word[31]), DW'(1));
        wr_ctl(mk(1, 1, 1, 0, 0, 1, 0, 5));
        check("R5", "drop clear no effect", DW'(wptr_word[31]), DW'(1));
        wr_ctl(mk(1, 1, 1, 1, 0, 1, 0, 5));
        check("R5", "second rising clear", DW'(wptr_word[31]), '0);

        cur_req = "R6";
        wr_ctl(mk(1, 1, 0, 0, 1, 0, 0, 5));
        set_rptr(96);                  // w=64 -> full
        check("R6", "ready low when full", DW'(vec_ready), '0);
        vec_valid = 1; vec_data = {8{32'h5B5B_000B}};
        repeat (3) begin
            tick();
            check("R6", "no write while held", DW'(mem_wr_en), '0);
            check("R6", "wptr held", DW'(wptr_word), DW'(64));
        end
        rptr_wr = 1; rptr_wdata = '0; tick(); rptr_wr = 0;
        check("R6", "still held on rptr edge", DW'(mem_wr_en), '0);
        tick(); vec_valid = 0;
        check("R6", "accepted after free", DW'(mem_wr_en), DW'(1));
        check("R6", "held data", mem_wr_data, {8{32'h5B5B_000B}});
        check("R6", "wptr moves", DW'(wptr_word), DW'(96));

        cur_req = "R11";
        wr_ctl(mk(1, 1, 0, 0, 0, 0, 0, 5));  // w=96 r=0 full
        push({8{32'h6C6C_000C}});
        check("R11", "written when full", DW'(mem_wr_en), DW'(1));
        check("R11", "no flag", DW'(wptr_word), '0);

        cur_req = "R9";
        wr_ctl(mk(1, 1, 0, 0, 0, 0, 1, 5));
        set_rptr(64);
        check("R9", "register ignored in doorbell mode", DW'(rptr_out), '0);
        ring_db(32);
        check("R9", "doorbell loads", DW'(rptr_out), DW'(32));
        wr_ctl(mk(1, 1, 0, 0, 0, 0, 0, 5));
        ring_db(96);
        check("R9", "doorbell ignored in register mode", DW'(rptr_out), DW'(32));
        set_rptr(64);
        check("R9", "register loads", DW'(rptr_out), DW'(64));

        cur_req = "R7";
        wr_ctl(mk(0, 1, 0, 0, 0, 0, 0, 5));
        check("R7", "ready low when off", DW'(vec_ready), '0);
        check("R7", "irq off when disabled", DW'(irq), '0);
        push({8{32'h7D7D_000D}});
        check("R7", "no write when off", DW'(mem_wr_en), '0);
        wptr_wr = 1; wptr_wdata = 16'd32; tick(); wptr_wr = 0;
        check("R7", "sw wptr load", DW'(wptr_word), DW'(32));
        wptr_wr = 1; wptr_wdata = '0; tick(); wptr_wr = 0;
        set_rptr(0);
        check("R7", "sw reset wptr", DW'(wptr_word), '0);
        check("R7", "sw reset rptr", DW'(rptr_out), '0);

        repeat (2) tick();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule